// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Unit

This block holds several independent down-counters behind a small synchronous register bus. Each channel has its own control word, an immediate-load register, a background reload register and a read-only current-value register. Software reads elapsed time by negating the current value.

A channel either runs periodically, reloading from its background value each time it passes zero, or runs once and parks at zero. Each channel can count every clock or once every 16 clocks, and it can use either its full 32-bit width or only the low 16 bits. A shared set of interrupt registers has one bit per channel: a mask, a raw status, a masked status and a write-one-to-clear port. One combined interrupt line is the OR of the masked status bits.

Read data is a combinational function of the address. Writes take effect at the clock edge on which the write strobe is high.

Top module: `mtimer_unit`

## Requirements
- R1: After reset every counter, reload value and control word reads 0, the mask and raw status read 0, and `irq_o` is low.
- R2: A write to a channel's load register (word address 16+4n+0) sets the counter to the written value, masked to the active width, at that write's edge. It also sets the reload value, which reads back at 16+4n+1. A disabled channel holds its count.
- R3: An enabled channel counting every clock decrements by exactly one per clock. The value register (16+4n+2) is read-only, and writes to it change nothing.
- R4: With the divide-by-16 bit set, the count drops once every 16 clocks, counted from the edge that enables the channel. Disabling a channel restarts its prescale phase.
- R5: In one-shot mode the counter raises one event as it reaches zero, then stays at zero and raises no further events until it is reloaded.
- R6: In periodic mode the tick after the count reaches zero reloads the background value. A write to the background register (16+4n+1) leaves the running count untouched. A background value of 0 makes the counter wrap to all ones.
- R7: With the width-select bit clear, loads are truncated to 16 bits and a zero reload wraps to 0xFFFF.
- R8: A channel's raw status bit (word 1) sets on the edge where its count becomes zero, whatever the mask says. Masked status (word 2) is raw AND mask (word 0). `irq_o` is high when any masked bit is set.
- R9: Writing 1s to the clear register (word 3) clears only those raw bits. An event in the same cycle as a clear of its bit leaves the bit set.
- R10: Control word (16+4n+3) bit 0 enables the channel, bit 1 selects one-shot, bit 2 selects the 32-bit width, and bit 3 selects divide-by-16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | AW | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Combinational read data |
| irq_o | output | 1 | Combined interrupt |

## Verification
A channel's zero-crossing event and a software clear of the same status bit can land on one clock edge. The bench arranges this by timing a clear write to commit on exactly the edge where a one-shot channel counts 1 to 0. It then judges the outcome by reading the raw status and `irq_o` on the following cycle, where the bit must still be set. The other overlap is a background write on the same edge as a decrement, which must leave the decrement intact.

// File: rtl/mtu_pkg.sv
// Shared constants and types for the timer unit.
// Assumes word addressing with four words per channel.
package mtu_pkg;
    localparam int REG_MASK  = 0;
    localparam int REG_RAW   = 1;
    localparam int REG_MIS   = 2;
    localparam int REG_CLR   = 3;
    localparam int CH_BASE   = 16;
    localparam int CH_STRIDE = 4;
    localparam int OFS_LOAD  = 0;
    localparam int OFS_BG    = 1;
    localparam int OFS_VAL   = 2;
    localparam int OFS_CTL   = 3;
    localparam int CTL_W     = 4;

    // Control word layout, bit 3 down to bit 0.
    typedef struct packed {
        logic div16;
        logic wide;
        logic oneshot;
        logic en;
    } ctl_t;
endpackage

// File: rtl/mtu_prescaler.sv
// Per-channel tick generator: either every clock or once per DIV clocks.
// Assumes DIV >= 2; the phase restarts whenever run is low.
module mtu_prescaler #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic div_sel,
    output logic tick
);
    localparam int PW = $clog2(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    // Phase counter: cleared while stopped, wraps at LAST while running.
    always_ff @(posedge clk) begin
        if (!rst_n)             phase <= '0;
        else if (!run)          phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    assign tick = run & (~div_sel | (phase == LAST));
endmodule

// File: rtl/mtu_channel.sv
// One down-counter with immediate load, background reload, one-shot/periodic
// behaviour and a narrow/wide width select. Assumes CW > NARROW.
// evt_o pulses combinationally in the cycle whose edge takes the count 1 -> 0.
module mtu_channel
    import mtu_pkg::*;
#(
    parameter int CW     = 32,
    parameter int NARROW = 16,
    parameter int DIV    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic          bg_we,
    input  logic          ctl_we,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] bg_o,
    output ctl_t          ctl_o,
    output logic          evt_o
);
    localparam logic [CW-1:0] NMASK = {{(CW-NARROW){1'b0}}, {NARROW{1'b1}}};

    ctl_t          ctl;
    logic [CW-1:0] cnt;
    logic [CW-1:0] bg;
    logic [CW-1:0] span;
    logic [CW-1:0] cur;
    logic [CW-1:0] bg_span;
    logic [CW-1:0] nxt;
    logic          tick;

    assign span    = ctl.wide ? {CW{1'b1}} : NMASK;
    assign cur     = cnt & span;
    assign bg_span = bg & span;

    mtu_prescaler #(.DIV(DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctl.en),
        .div_sel (ctl.div16),
        .tick    (tick)
    );

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl <= '0;
        else if (ctl_we) ctl <= ctl_t'(wdata[CTL_W-1:0]);
    end

    // Reload value: written by both the load and the background ports.
    always_ff @(posedge clk) begin
        if (!rst_n)              bg <= '0;
        else if (ld_we || bg_we) bg <= wdata;
    end

    // Next count on a tick: decrement, park, reload, or wrap.
    always_comb begin
        if (cur == '0) begin
            if (ctl.oneshot)        nxt = '0;
            else if (bg_span == '0) nxt = span;
            else                    nxt = bg_span;
        end else begin
            nxt = cur - 1'b1;
        end
    end

    // Counter: a load write wins over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (ld_we) cnt <= wdata & span;
        else if (tick)  cnt <= nxt;
    end

    assign evt_o = tick & ~ld_we & (cur == CW'(1));
    assign cnt_o = cur;
    assign bg_o  = bg;
    assign ctl_o = ctl;
endmodule

// File: rtl/mtu_irq.sv
// Shared interrupt logic: mask, raw status with write-one-to-clear, and the
// combined line. Assumes evt is a single-cycle pulse per channel.
module mtu_irq #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mask_we,
    input  logic           clr_we,
    input  logic [NCH-1:0] wbits,
    input  logic [NCH-1:0] evt,
    output logic [NCH-1:0] mask_o,
    output logic [NCH-1:0] raw_o,
    output logic [NCH-1:0] mis_o,
    output logic           irq_o
);
    logic [NCH-1:0] mask;
    logic [NCH-1:0] raw;
    logic [NCH-1:0] clr_bits;

    assign clr_bits = clr_we ? wbits : '0;

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= wbits;
    end

    // Raw status: a new event beats a clear of the same bit.
    always_ff @(posedge clk) begin
        if (!rst_n) raw <= '0;
        else        raw <= (raw & ~clr_bits) | evt;
    end

    assign mask_o = mask;
    assign raw_o  = raw;
    assign mis_o  = raw & mask;
    assign irq_o  = |(raw & mask);
endmodule

// File: rtl/mtimer_unit.sv
// Timer unit top: address decode, per-channel counters, interrupt block and
// the read mux. Assumes NCH <= CW and that the channel window fits in AW bits.
module mtimer_unit
    import mtu_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int CW      = 32,
    parameter int AW      = 8,
    parameter int NARROW  = 16,
    parameter int PRE_DIV = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    output logic          irq_o
);
    localparam int CH_TOP = CH_BASE + CH_STRIDE * NCH;

    logic                          in_ch;
    logic [AW-1:0]                 ch_rel;
    logic [AW-3:0]                 ch_sel;
    logic [1:0]                    ofs;
    logic [NCH-1:0]                ld_we;
    logic [NCH-1:0]                bg_we;
    logic [NCH-1:0]                ctl_we;
    logic [NCH-1:0]                ch_evt;
    logic [NCH-1:0][CW-1:0]        ch_cnt;
    logic [NCH-1:0][CW-1:0]        ch_bg;
    logic [NCH-1:0][CTL_W-1:0]     ch_ctl;
    logic                          mask_we;
    logic                          clr_we;
    logic [NCH-1:0]                wbits;
    logic [NCH-1:0]                irq_mask;
    logic [NCH-1:0]                irq_raw;
    logic [NCH-1:0]                irq_mis;

    assign in_ch   = (bus_addr >= AW'(CH_BASE)) && ({1'b0, bus_addr} < (AW+1)'(CH_TOP));
    assign ch_rel  = bus_addr - AW'(CH_BASE);
    assign ch_sel  = ch_rel[AW-1:2];
    assign ofs     = ch_rel[1:0];
    assign mask_we = bus_we && (bus_addr == AW'(REG_MASK));
    assign clr_we  = bus_we && (bus_addr == AW'(REG_CLR));
    assign wbits   = bus_wdata[NCH-1:0];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit;
        ctl_t ctl_g;
        assign hit       = bus_we && in_ch && (ch_sel == (AW-2)'(g));
        assign ld_we[g]  = hit && (ofs == 2'(OFS_LOAD));
        assign bg_we[g]  = hit && (ofs == 2'(OFS_BG));
        assign ctl_we[g] = hit && (ofs == 2'(OFS_CTL));
        assign ch_ctl[g] = ctl_g;

        mtu_channel #(.CW(CW), .NARROW(NARROW), .DIV(PRE_DIV)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld_we  (ld_we[g]),
            .bg_we  (bg_we[g]),
            .ctl_we (ctl_we[g]),
            .wdata  (bus_wdata),
            .cnt_o  (ch_cnt[g]),
            .bg_o   (ch_bg[g]),
            .ctl_o  (ctl_g),
            .evt_o  (ch_evt[g])
        );
    end

    mtu_irq #(.NCH(NCH)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (mask_we),
        .clr_we  (clr_we),
        .wbits   (wbits),
        .evt     (ch_evt),
        .mask_o  (irq_mask),
        .raw_o   (irq_raw),
        .mis_o   (irq_mis),
        .irq_o   (irq_o)
    );

    // Read mux: channel window first, then the shared words.
    always_comb begin
        bus_rdata = '0;
        if (in_ch) begin
            for (int c = 0; c < NCH; c++) begin
                if (ch_sel == (AW-2)'(c)) begin
                    case (ofs)
                        2'(OFS_LOAD), 2'(OFS_BG): bus_rdata = ch_bg[c];
                        2'(OFS_VAL):              bus_rdata = ch_cnt[c];
                        default:                  bus_rdata = {{(CW-CTL_W){1'b0}}, ch_ctl[c]};
                    endcase
                end
            end
        end else if (bus_addr == AW'(REG_MASK)) begin
            bus_rdata = {{(CW-NCH){1'b0}}, irq_mask};
        end else if (bus_addr == AW'(REG_RAW)) begin
            bus_rdata = {{(CW-NCH){1'b0}}, irq_raw};
        end else if (bus_addr == AW'(REG_MIS)) begin
            bus_rdata = {{(CW-NCH){1'b0}}, irq_mis};
        end
    end
endmodule

// File: rtl/mtimer_unit_chk.sv
// Checker for the timer unit, bound to the top. Observes per-channel counts,
// control words, write strobes and interrupt state.
module mtimer_unit_chk #(
    parameter int NCH = 4,
    parameter int CW  = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   irq_o,
    input logic [NCH-1:0][CW-1:0] cnt,
    input logic [NCH-1:0][3:0]    ctl,
    input logic [NCH-1:0]         ld_we,
    input logic [NCH-1:0]         ctl_we,
    input logic [NCH-1:0]         evt,
    input logic [NCH-1:0]         raw,
    input logic                   clr_we,
    input logic [NCH-1:0]         wbits
);
    // R1: the interrupt line is quiet as reset releases.
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_o);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R9: an event always lands in raw status, even against a clear.
        a_r9_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
            evt[g] |=> raw[g]);

        // R9: a clear with no competing event drops the bit.
        a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && wbits[g] && !evt[g]) |=> !raw[g]);

        // R8: raw status rises only with the counter at zero.
        a_r8_raw_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(raw[g]) |-> (cnt[g] == '0));

        // R5: a running one-shot channel parks at zero.
        a_r5_oneshot_parks: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl[g][0] && ctl[g][1] && cnt[g] == '0 && !ld_we[g]) |=> (cnt[g] == '0));

        // R3: undivided counting steps down by one.
        a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl[g][0] && !ctl[g][3] && !ld_we[g] && !ctl_we[g] && cnt[g] > CW'(1))
            |=> (cnt[g] == $past(cnt[g]) - CW'(1)));
    end
endmodule

bind mtimer_unit mtimer_unit_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_o  (irq_o),
    .cnt    (ch_cnt),
    .ctl    (ch_ctl),
    .ld_we  (ld_we),
    .ctl_we (ctl_we),
    .evt    (ch_evt),
    .raw    (irq_raw),
    .clr_we (clr_we),
    .wbits  (wbits)
);

// File: tb/mtimer_unit_test.sv
// Directed bench: inputs change just after falling edges, outputs are sampled 1 ns later.
module mtimer_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          checks = 0;
    int          fails = 0;

    localparam logic [7:0] A_MASK = 8'd0, A_RAW = 8'd1, A_MIS = 8'd2, A_CLR = 8'd3;

    always #10 clk = ~clk;

    mtimer_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_o     (irq)
    );

    function automatic logic [7:0] ca(int n, int o);
        return 8'(16 + 4 * n + o);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic exp_reg(string tag, logic [7:0] a, logic [31:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        exp_reg("R1 mask", A_MASK, 0);
        exp_reg("R1 raw", A_RAW, 0);
        exp_reg("R1 value", ca(0, 2), 0);
        exp_reg("R1 reload", ca(1, 1), 0);
        exp_reg("R1 ctrl", ca(2, 3), 0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_load;
        wr(ca(0, 0), 100);
        exp_reg("R2 immediate load", ca(0, 2), 100);
        exp_reg("R2 reload copy", ca(0, 1), 100);
        idle(5);
        exp_reg("R2 disabled hold", ca(0, 2), 100);
        wr(ca(0, 2), 32'h55);
        exp_reg("R3 value read-only", ca(0, 2), 100);
    endtask

    task automatic t_div1;
        wr(ca(0, 3), 32'h5);
        exp_reg("R10 ctrl readback", ca(0, 3), 32'h5);
        idle(7);
        exp_reg("R3 one per clock", ca(0, 2), 93);
        wr(ca(0, 3), 0);
    endtask

    task automatic t_div16;
        wr(ca(1, 0), 10);
        wr(ca(1, 3), 32'hD);
        idle(15);
        exp_reg("R4 no tick before 16", ca(1, 2), 10);
        idle(1);
        exp_reg("R4 tick at 16", ca(1, 2), 9);
        idle(5);
        wr(ca(1, 3), 0);
        idle(2);
        wr(ca(1, 3), 32'hD);
        idle(15);
        exp_reg("R4 phase restarted", ca(1, 2), 9);
        idle(1);
        exp_reg("R4 tick after restart", ca(1, 2), 8);
        wr(ca(1, 3), 0);
    endtask

    task automatic t_oneshot;
        wr(A_MASK, 32'h4);
        wr(ca(2, 0), 3);
        wr(ca(2, 3), 32'h7);
        idle(2);
        exp_reg("R5 count 1", ca(2, 2), 1);
        exp_reg("R8 raw not yet", A_RAW, 0);
        chk("R8 irq not yet", 32'(irq), 0);
        idle(1);
        exp_reg("R5 zero", ca(2, 2), 0);
        exp_reg("R8 raw at zero", A_RAW, 32'h4);
        exp_reg("R8 masked", A_MIS, 32'h4);
        chk("R8 irq high", 32'(irq), 1);
        idle(5);
        exp_reg("R5 parked", ca(2, 2), 0);
        wr(A_CLR, 32'h4);
        exp_reg("R9 cleared", A_RAW, 0);
        chk("R9 irq low", 32'(irq), 0);
        idle(10);
        exp_reg("R5 no second event", A_RAW, 0);
    endtask

    task automatic t_periodic;
        wr(ca(3, 0), 4);
        wr(ca(3, 3), 32'h5);
        wr(ca(3, 1), 9);
        exp_reg("R6 bg write keeps count", ca(3, 2), 3);
        idle(3);
        exp_reg("R6 reached zero", ca(3, 2), 0);
        exp_reg("R8 raw unmasked", A_RAW, 32'h8);
        exp_reg("R8 masked excludes", A_MIS, 0);
        chk("R8 irq stays low", 32'(irq), 0);
        idle(1);
        exp_reg("R6 reload from bg", ca(3, 2), 9);
        wr(ca(3, 1), 0);
        idle(8);
        exp_reg("R6 zero again", ca(3, 2), 0);
        idle(1);
        exp_reg("R6 wrap full", ca(3, 2), 32'hFFFF_FFFF);
        wr(ca(3, 3), 0);
    endtask

    task automatic t_narrow;
        wr(ca(0, 0), 32'h1234_0002);
        exp_reg("R7 truncated load", ca(0, 2), 2);
        wr(ca(0, 1), 0);
        wr(ca(0, 3), 32'h1);
        idle(2);
        exp_reg("R7 raw bit0", A_RAW, 32'h9);
        idle(1);
        exp_reg("R7 wrap 16", ca(0, 2), 32'hFFFF);
        wr(ca(0, 3), 0);
    endtask

    task automatic t_collide;
        wr(A_CLR, 32'h8);
        exp_reg("R9 selective clear", A_RAW, 32'h1);
        wr(A_MASK, 32'h2);
        wr(ca(1, 0), 2);
        wr(ca(1, 3), 32'h7);
        idle(1);
        wr(A_CLR, 32'h2);
        exp_reg("R9 set beats clear", A_RAW, 32'h3);
        chk("R9 irq after collide", 32'(irq), 1);
        wr(A_CLR, 32'h2);
        exp_reg("R9 later clear", A_RAW, 32'h1);
        chk("R8 irq masked off", 32'(irq), 0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset;
        t_load;
        t_div1;
        t_div16;
        t_oneshot;
        t_periodic;
        t_narrow;
        t_collide;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule